// File: doc/BRIEF.md
# Partitioned SIMD Add, Subtract and Compare Unit

This unit treats each 64-bit operand as a row of independent fixed-point lanes. The lanes are either four 16-bit lanes or two 32-bit lanes. It adds or subtracts matching lanes with no carry crossing between lanes. It can also compare matching lanes as signed numbers and pack one flag per lane into the low bits of an integer-style result.

The arithmetic has two forms. The full form writes all 64 bits. The half form computes only the lanes in the low 32 bits and passes the upper 32 bits of the old destination value through unchanged.

The operation is decoded from a few opcode fields and computed in one combinational pass. The answer is captured in an output register together with a valid flag, so a result appears one clock after the request.

Top module: `simd_partitioned_alu`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first request, `out_valid` is 0 and `result` is all zeros.
- R2: A request accepted with `in_valid`=1 on a rising edge produces `out_valid`=1 and its `result` after that same edge. In a cycle with `in_valid`=0, `out_valid` falls to 0 and `result` keeps its last value.
- R3: Full-form add (`op_kind`=2'b00, `half_form`=0) with `lane_wide`=0 adds four 16-bit lanes. Lane i occupies bits [16i+15:16i]. Each lane wraps modulo 2^16 and passes no carry into its neighbour.
- R4: Full-form add with `lane_wide`=1 adds two 32-bit lanes, bits [31:0] and [63:32]. Each lane wraps modulo 2^32 with no carry between the two lanes.
- R5: Subtract (`op_kind`=2'b01) computes `src_a` lane minus `src_b` lane for each lane of the selected width. Each lane wraps modulo 2^lane-width, with no borrow between lanes.
- R6: In the half form (`half_form`=1, arithmetic ops only), bits [31:0] hold the two 16-bit lane results or the one 32-bit lane result. Bits [63:32] equal `dst_old[63:32]` of the same request.
- R7: In the full form of add and subtract, `dst_old` has no effect on `result`.
- R8: Compares (`op_kind[1]`=1) treat each lane as a two's-complement signed value. `cmp_sel` picks the test of `src_a` lane against `src_b` lane: 0 = greater-than, 1 = less-or-equal, 2 = equal, 3 = not-equal.
- R9: The compare flag of lane i is placed in `result` bit i. This gives 4 flag bits for 16-bit lanes and 2 for 32-bit lanes. Every higher result bit is 0, and `half_form` and `dst_old` have no effect on a compare.
- R10: `op_kind[0]` is ignored when `op_kind[1]`=1, so opcodes 2'b10 and 2'b11 both select a compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for the current cycle |
| op_kind | input | 2 | Bit 1: compare; bit 0: subtract (arithmetic only) |
| lane_wide | input | 1 | 0 = four 16-bit lanes, 1 = two 32-bit lanes |
| half_form | input | 1 | 1 = arithmetic writes only the low 32 bits |
| cmp_sel | input | 2 | Compare test: GT, LE, EQ, NE |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| dst_old | input | 64 | Previous destination value, used for the half form |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Registered lane-wise result or packed compare flags |

## Verification
The assertions assume that `src_a`, `src_b`, `dst_old` and the opcode fields always carry known 0/1 values, including in idle cycles. This matters because the lane inverse checks look at the arithmetic every cycle, whatever `in_valid` is. They also assume that `rst_n` is held low across at least one rising edge.

The stimulus drives every input to a defined value from time zero. It changes the inputs only on falling edges and drives zeros during reset. Random requests use the full 64-bit operand range with all opcode combinations, and directed ones cover the lane-boundary carry and signed-edge values.

// File: rtl/simd_pkg.sv
package simd_pkg;

  // Compare selector encodings.
  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LE = 2'd1,
    CMP_EQ = 2'd2,
    CMP_NE = 2'd3
  } cmp_e;

  // Derive one compare flag from greater-than and equal indications.
  function automatic logic pick_flag(cmp_e sel, logic gt, logic eq);
    logic f;
    case (sel)
      CMP_GT:  f = gt;
      CMP_LE:  f = ~gt;
      CMP_EQ:  f = eq;
      default: f = ~eq;
    endcase
    return f;
  endfunction

  // Keep the upper half of the old destination, take the lower half of fresh data.
  function automatic logic [63:0] merge_low_half(logic [63:0] fresh, logic [63:0] old);
    return {old[63:32], fresh[31:0]};
  endfunction

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  localparam int LANES = DATA_W / LANE_W;

  // Per-lane add or subtract; the width of the function bounds every carry.
  function automatic logic [LANE_W-1:0] lane_calc(logic [LANE_W-1:0] x,
                                                  logic [LANE_W-1:0] y,
                                                  logic do_sub);
    logic [LANE_W-1:0] yy;
    yy = do_sub ? ~y : y;
    return x + yy + {{(LANE_W-1){1'b0}}, do_sub};
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, r_l;
    assign a_l = a[l*LANE_W +: LANE_W];
    assign b_l = b[l*LANE_W +: LANE_W];
    assign r_l = lane_calc(a_l, b_l, sub);
    assign res[l*LANE_W +: LANE_W] = r_l;

    // R3 R4 R5: undoing the lane operation recovers the first operand, lane by lane
    a_r5_lane_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (sub ? LANE_W'(r_l + b_l) : LANE_W'(r_l - b_l)) == a_l);
  end

endmodule

// File: rtl/simd_cmp.sv
module simd_cmp #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DATA_W-1:0]           a,
  input  logic [DATA_W-1:0]           b,
  output logic [DATA_W/LANE_W-1:0]    gt,
  output logic [DATA_W/LANE_W-1:0]    eq
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [LANE_W-1:0] sa, sb;
    assign sa    = $signed(a[l*LANE_W +: LANE_W]);
    assign sb    = $signed(b[l*LANE_W +: LANE_W]);
    assign gt[l] = sa > sb;
    assign eq[l] = a[l*LANE_W +: LANE_W] == b[l*LANE_W +: LANE_W];
  end

  // R8: a lane cannot be both greater and equal
  a_r8_gt_eq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (gt & eq) == '0);

endmodule

// File: rtl/simd_partitioned_alu.sv
module simd_partitioned_alu
  import simd_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  op_kind,
  input  logic        lane_wide,
  input  logic        half_form,
  input  logic [1:0]  cmp_sel,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic [63:0] dst_old,
  output logic        out_valid,
  output logic [63:0] result
);
  localparam int N_LANES = DATA_W / NARROW_W;
  localparam int W_LANES = DATA_W / WIDE_W;

  // Decoded request fields
  logic is_cmp, is_sub;
  cmp_e csel;
  assign is_cmp = op_kind[1];
  assign is_sub = op_kind[0];
  assign csel   = cmp_e'(cmp_sel);

  // Arithmetic paths for both lane widths
  logic [DATA_W-1:0] narrow_sum, wide_sum, arith;

  simd_addsub #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_add_narrow (
    .clk(clk), .rst_n(rst_n), .sub(is_sub), .a(src_a), .b(src_b), .res(narrow_sum)
  );
  simd_addsub #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) u_add_wide (
    .clk(clk), .rst_n(rst_n), .sub(is_sub), .a(src_a), .b(src_b), .res(wide_sum)
  );

  assign arith = lane_wide ? wide_sum : narrow_sum;

  // Compare paths for both lane widths
  logic [N_LANES-1:0] n_gt, n_eq, n_flag;
  logic [W_LANES-1:0] w_gt, w_eq, w_flag;

  simd_cmp #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_cmp_narrow (
    .clk(clk), .rst_n(rst_n), .a(src_a), .b(src_b), .gt(n_gt), .eq(n_eq)
  );
  simd_cmp #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) u_cmp_wide (
    .clk(clk), .rst_n(rst_n), .a(src_a), .b(src_b), .gt(w_gt), .eq(w_eq)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_nflag
    assign n_flag[i] = pick_flag(csel, n_gt[i], n_eq[i]);
  end
  for (genvar i = 0; i < W_LANES; i++) begin : g_wflag
    assign w_flag[i] = pick_flag(csel, w_gt[i], w_eq[i]);
  end

  // Packed compare word: lane i flag at bit i, upper bits zero
  logic [DATA_W-1:0] cmp_word;
  always_comb begin
    cmp_word = '0;
    if (lane_wide) cmp_word[W_LANES-1:0] = w_flag;
    else           cmp_word[N_LANES-1:0] = n_flag;
  end

  // Final selection before the output register
  logic [DATA_W-1:0] next_result;
  always_comb begin
    if (is_cmp)         next_result = cmp_word;
    else if (half_form) next_result = merge_low_half(arith, dst_old);
    else                next_result = arith;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end

  // R2: valid follows the request by one cycle
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2: idle cycles hold the result
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R6: half form carries the old upper half through
  a_r6_upper_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_kind[1] && half_form) |=> result[63:32] == $past(dst_old[63:32]));
  // R9: unused compare bits stay zero
  a_r9_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind[1] && !lane_wide) |=> result[DATA_W-1:N_LANES] == '0);
  a_r9_wide_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind[1] && lane_wide) |=> result[DATA_W-1:W_LANES] == '0);

endmodule

// File: tb/simd_partitioned_alu_tb.sv
module simd_partitioned_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic        lane_wide = 1'b0;
  logic        half_form = 1'b0;
  logic [1:0]  cmp_sel = 2'd0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] dst_old = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] last_exp = '0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  simd_partitioned_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
    .lane_wide(lane_wide), .half_form(half_form), .cmp_sel(cmp_sel),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .out_valid(out_valid), .result(result)
  );

  // Independent reference: shift-and-mask per lane, signed values as integers
  function automatic logic [63:0] model(logic [1:0] op, logic wide, logic half,
                                        logic [1:0] cs, logic [63:0] a,
                                        logic [63:0] b, logic [63:0] d);
    int lw;
    int n;
    longint unsigned mask;
    logic [63:0] r;
    lw   = wide ? 32 : 16;
    n    = 64 / lw;
    mask = (64'd1 << lw) - 64'd1;
    r    = '0;
    if (op[1]) begin
      for (int i = 0; i < n; i++) begin
        longint xa, xb;
        bit f;
        xa = longint'((a >> (i*lw)) & mask);
        xb = longint'((b >> (i*lw)) & mask);
        if (xa >= (64'sd1 <<< (lw-1))) xa = xa - (64'sd1 <<< lw);
        if (xb >= (64'sd1 <<< (lw-1))) xb = xb - (64'sd1 <<< lw);
        case (cs)
          2'd0: f = xa > xb;
          2'd1: f = xa <= xb;
          2'd2: f = xa == xb;
          default: f = xa != xb;
        endcase
        r[i] = f;
      end
    end else begin
      int cnt;
      cnt = half ? n/2 : n;
      for (int i = 0; i < cnt; i++) begin
        longint unsigned x, y, z;
        x = (a >> (i*lw)) & mask;
        y = (b >> (i*lw)) & mask;
        z = op[0] ? ((x - y) & mask) : ((x + y) & mask);
        r = r | (z << (i*lw));
      end
      if (half) r[63:32] = d[63:32];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply one request on a falling edge and queue its expected result
  task automatic drive(string tag, logic [1:0] op, logic wide, logic half,
                       logic [1:0] cs, logic [63:0] a, logic [63:0] b,
                       logic [63:0] d);
    item_t it;
    @(negedge clk);
    in_valid  = 1'b1;
    op_kind   = op;
    lane_wide = wide;
    half_form = half;
    cmp_sel   = cs;
    src_a     = a;
    src_b     = b;
    dst_old   = d;
    it.exp    = model(op, wide, half, cs, a, b, d);
    it.tag    = tag;
    last_exp  = it.exp;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a    = {$urandom, $urandom};
      src_b    = {$urandom, $urandom};
      dst_old  = {$urandom, $urandom};
    end
  endtask

  // Monitor: pop and compare whenever a result is flagged valid
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2: unexpected out_valid, actual 1 expected 0");
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, result, it.exp);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R1 result after reset", result, 64'd0);

    // R3: 16-bit lanes, carry isolation and wrap
    drive("R3 narrow add boundary", 2'b00, 0, 0, 0, 64'h7fff_ffff_0001_ffff, 64'h0001_0001_ffff_0001, '0);
    drive("R3 narrow add mixed", 2'b00, 0, 0, 0, 64'h1234_8000_00ff_ffff, 64'h4321_8000_ff01_ffff, '0);
    // R4: 32-bit lanes
    drive("R4 wide add wrap", 2'b00, 1, 0, 0, 64'h0000_0000_ffff_ffff, 64'h0000_0000_0000_0001, '0);
    drive("R4 wide add mixed", 2'b00, 1, 0, 0, 64'h8000_0000_7fff_ffff, 64'h8000_0000_0000_0001, '0);
    // R5: subtract with borrow isolation
    drive("R5 narrow sub", 2'b01, 0, 0, 0, 64'h0000_0001_0000_8000, 64'h0001_0001_0001_0001, '0);
    drive("R5 wide sub", 2'b01, 1, 0, 0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, '0);
    // R6: half form
    drive("R6 half narrow add", 2'b00, 0, 1, 0, 64'h1111_2222_ffff_0001, 64'h3333_4444_0001_ffff, 64'hdead_beef_cafe_f00d);
    drive("R6 half wide sub", 2'b01, 1, 1, 0, 64'h9999_9999_0000_0000, 64'h1111_1111_0000_0001, 64'h0123_4567_89ab_cdef);
    // R7: full form ignores dst_old
    drive("R7 full ignores dst_old", 2'b00, 0, 0, 0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 64'hffff_ffff_ffff_ffff);
    // R8: signed compare types
    drive("R8 narrow GT", 2'b10, 0, 0, 2'd0, 64'h7fff_8000_0001_0005, 64'h8000_7fff_ffff_0005, '0);
    drive("R8 narrow LE", 2'b10, 0, 0, 2'd1, 64'h7fff_8000_0001_0005, 64'h8000_7fff_ffff_0005, '0);
    drive("R8 narrow EQ", 2'b10, 0, 0, 2'd2, 64'h0005_1234_ffff_0000, 64'h0005_1235_ffff_0001, '0);
    drive("R8 wide NE", 2'b10, 1, 0, 2'd3, 64'h8000_0000_0000_0007, 64'h8000_0000_0000_0008, '0);
    drive("R8 wide GT", 2'b10, 1, 0, 2'd0, 64'h0000_0001_ffff_ffff, 64'hffff_ffff_0000_0000, '0);
    // R9: packing, half_form and dst_old ignored
    drive("R9 compare with half and dst_old", 2'b10, 0, 1, 2'd3, 64'h0001_0000_0001_0000, 64'h0000_0000_0000_0000, 64'hffff_ffff_ffff_ffff);
    // R10: op_kind 2'b11 still compares
    drive("R10 opcode 3 compares", 2'b11, 1, 0, 2'd1, 64'h0000_0005_ffff_fff0, 64'h0000_0005_0000_0010, '0);
    // R2: idle hold
    idle(1);
    idle(2);
    check("R2 out_valid idle", {63'd0, out_valid}, 64'd0);
    check("R2 result held", result, last_exp);

    // Random mix, back-to-back with idle gaps
    for (int k = 0; k < 400; k++) begin
      logic [1:0] op;
      logic w, h;
      string tag;
      op = 2'($urandom);
      w  = 1'($urandom);
      h  = 1'($urandom);
      if (op[1])   tag = "R8 R9 random compare";
      else if (h)  tag = "R6 random half";
      else if (w)  tag = "R4 R5 random wide";
      else         tag = "R3 R5 random narrow";
      drive(tag, op, w, h, 2'($urandom), {$urandom, $urandom},
            {$urandom, $urandom}, {$urandom, $urandom});
      if (($urandom % 5) == 0) idle(1);
    end
    idle(3);
    check("R2 queue drained", 64'(sb_q.size()), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule